// File: doc/BRIEF.md
# Protection Region Register File

This block is the software-visible register file of a small memory protection unit. It decodes single-word reads and writes at fixed 12-bit offsets. It stores the global control bits, a region selector, and one base address word and one attribute/size word for each implemented region. The number of regions is a parameter from 0 to 16.

The base/attribute pair can be reached at four offset pairs, and every pair maps to the same storage. A base write can name its target region directly and move the selector to that region at the same time, so software can program a region in two stores. Bits that are not implemented are masked off when written.

Read data is combinational from the offset. Every accepted write to the control, base or attribute storage raises a one-cycle `prot_changed` pulse, which tells downstream lookup logic to drop any cached permissions. A control write that sets an undefined combination raises `ctrl_bad`. The address check against the regions is not part of this block.

Top module: `mpu_regfile`

## Requirements
- R1: Offset 0xD90 is read-only. It reads the parameter NUM_REGIONS in bits 15:8 and zero in all other bits. A write to it changes nothing and raises no `prot_changed` pulse.
- R2: Offset 0xD94 holds three control bits: bit 0 enable, bit 1 active-in-fault-handlers and bit 2 privileged default map. The other written bits are dropped and read as zero.
- R3: A control write whose bits 1:0 are 2'b10 raises `ctrl_bad` for exactly the cycle after the write. Any other control value leaves `ctrl_bad` low.
- R4: Offset 0xD98 is the region selector and reads back in bits 3:0. A write whose full 32-bit value is not below NUM_REGIONS is ignored, and the old selection is kept. For example, 0x13 is not truncated to 3.
- R5: A write to a base offset with bit 4 set targets the region in bits 3:0 and also copies that number into the selector. If that region is not below NUM_REGIONS, the whole write is dropped: the selector and all storage stay unchanged.
- R6: A write to a base offset with bit 4 clear targets the selected region and stores the value with bits 4:0 cleared. A base read returns the stored bits 31:5, zero in bit 4, and the selector in bits 3:0.
- R7: An attribute write stores bits 15:0 ANDed with 0xFF3F as size/enable and bits 31:16 ANDed with 0x173F as access control, both for the selected region. A read returns access control in 31:16 and size/enable in 15:0.
- R8: The base/attribute pairs at 0xD9C/0xDA0, 0xDA4/0xDA8, 0xDAC/0xDB0 and 0xDB4/0xDB8 all access the same storage of the selected region.
- R9: Any other offset reads zero, and a write to it has no effect. When the selected region is out of range, base and attribute reads return zero and attribute writes are dropped.
- R10: `prot_changed` is high for one cycle after each accepted write to the control, base or attribute storage. A selector write or a dropped write raises no pulse.
- R11: After reset, all storage, the selector and both pulse outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 12 | Word offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| prot_changed | output | 1 | One-cycle pulse after an accepted protection write |
| ctrl_bad | output | 1 | One-cycle pulse after an undefined control setting |

## Verification
The properties assume that `rst_n` is held low across at least one clock edge and that `wr_en` is low during reset, because the past-value checks look one cycle back from the first enabled edge. They also take `addr` and `wdata` as stable for the whole cycle in which `wr_en` is high. The stimulus meets these assumptions: it changes inputs only shortly after a rising edge, and it drives exactly one access per cycle with `wr_en` low during reset. The region-range property is only meaningful when at least one region exists, so it is generated only for that case. The bench runs the default of eight regions.

// File: rtl/mpu_regfile_pkg.sv
package mpu_regfile_pkg;
   localparam int ADDR_W      = 12;
   localparam int DATA_W      = 32;
   localparam int IDX_W       = 4;
   localparam int MAX_REGIONS = 16;
   localparam int ALIAS_PAIRS = 4;
   localparam int BASE_LSB    = 5;

   localparam logic [ADDR_W-1:0] OFF_INFO  = 12'hD90;
   localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'hD94;
   localparam logic [ADDR_W-1:0] OFF_SEL   = 12'hD98;
   localparam logic [ADDR_W-1:0] OFF_PAIR0 = 12'hD9C;
   localparam logic [ADDR_W-1:0] PAIR_STEP = 12'h008;

   localparam logic [15:0] SIZE_KEEP = 16'hFF3F;
   localparam logic [15:0] ACC_KEEP  = 16'h173F;

   typedef enum logic [2:0] {
      RK_NONE, RK_INFO, RK_CTRL, RK_SEL, RK_BASE, RK_ATTR
   } reg_kind_e;
endpackage

// File: rtl/mpu_regfile_decode.sv
module mpu_regfile_decode
   import mpu_regfile_pkg::*;
(
   input  logic [ADDR_W-1:0] addr,
   output reg_kind_e         kind
);
   always_comb begin
      kind = RK_NONE;
      unique case (addr)
         OFF_INFO: kind = RK_INFO;
         OFF_CTRL: kind = RK_CTRL;
         OFF_SEL:  kind = RK_SEL;
         default: begin
            for (int p = 0; p < ALIAS_PAIRS; p++) begin
               if (addr == OFF_PAIR0 + ADDR_W'(p) * PAIR_STEP)
                  kind = RK_BASE;
               if (addr == OFF_PAIR0 + ADDR_W'(p) * PAIR_STEP + 12'h004)
                  kind = RK_ATTR;
            end
         end
      endcase
   end
endmodule

// File: rtl/mpu_region_bank.sv
module mpu_region_bank
   import mpu_regfile_pkg::*;
#(
   parameter int NUM_REGIONS = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       base_we,
   input  logic [IDX_W-1:0]           base_idx,
   input  logic [DATA_W-BASE_LSB-1:0] base_in,
   input  logic                       attr_we,
   input  logic [IDX_W-1:0]           attr_idx,
   input  logic [15:0]                size_in,
   input  logic [15:0]                acc_in,
   input  logic [IDX_W-1:0]           rd_idx,
   output logic [DATA_W-BASE_LSB-1:0] rd_base,
   output logic [15:0]                rd_size,
   output logic [15:0]                rd_acc
);
   localparam int BASE_W = DATA_W - BASE_LSB;

   generate
      if (NUM_REGIONS > 0) begin : g_bank
         logic [BASE_W-1:0] base_q [NUM_REGIONS];
         logic [15:0]       size_q [NUM_REGIONS];
         logic [15:0]       acc_q  [NUM_REGIONS];

         for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_reg
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  base_q[r] <= '0;
                  size_q[r] <= '0;
                  acc_q[r]  <= '0;
               end else begin
                  if (base_we && base_idx == IDX_W'(r))
                     base_q[r] <= base_in;
                  if (attr_we && attr_idx == IDX_W'(r)) begin
                     size_q[r] <= size_in & SIZE_KEEP;
                     acc_q[r]  <= acc_in & ACC_KEEP;
                  end
               end
            end
         end

         always_comb begin
            rd_base = '0;
            rd_size = '0;
            rd_acc  = '0;
            for (int r = 0; r < NUM_REGIONS; r++) begin
               if (rd_idx == IDX_W'(r)) begin
                  rd_base = base_q[r];
                  rd_size = size_q[r];
                  rd_acc  = acc_q[r];
               end
            end
         end
      end else begin : g_empty
         assign rd_base = '0;
         assign rd_size = '0;
         assign rd_acc  = '0;
      end
   endgenerate
endmodule

// File: rtl/mpu_regfile.sv
module mpu_regfile
   import mpu_regfile_pkg::*;
#(
   parameter int NUM_REGIONS = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [11:0] addr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output logic        prot_changed,
   output logic        ctrl_bad
);
   localparam int CNT_W  = IDX_W + 1;
   localparam int BASE_W = DATA_W - BASE_LSB;
   localparam logic [CNT_W-1:0] REG_CNT = CNT_W'(NUM_REGIONS);

   generate
      if (NUM_REGIONS < 0 || NUM_REGIONS > MAX_REGIONS) begin : g_bad_cfg
         $error("mpu_regfile: NUM_REGIONS must lie in 0..16");
      end
   endgenerate

   reg_kind_e        kind;
   logic [2:0]       ctrl_q;
   logic [IDX_W-1:0] sel_q;
   logic             changed_q, bad_q;

   mpu_regfile_decode u_dec (.addr(addr), .kind(kind));

   // Region targeted by a base write: own number when bit 4 is set.
   logic [IDX_W-1:0] base_tgt;
   logic             tgt_ok, sel_ok, sel_val_ok;
   assign base_tgt   = wdata[4] ? wdata[IDX_W-1:0] : sel_q;
   assign tgt_ok     = {1'b0, base_tgt} < REG_CNT;
   assign sel_ok     = {1'b0, sel_q} < REG_CNT;
   assign sel_val_ok = wdata < DATA_W'(NUM_REGIONS);

   logic wr_ctrl, wr_sel, base_acc, attr_acc;
   assign wr_ctrl  = wr_en && kind == RK_CTRL;
   assign wr_sel   = wr_en && kind == RK_SEL;
   assign base_acc = wr_en && kind == RK_BASE && tgt_ok;
   assign attr_acc = wr_en && kind == RK_ATTR && sel_ok;

   logic [BASE_W-1:0] rd_base;
   logic [15:0]       rd_size, rd_acc;

   mpu_region_bank #(.NUM_REGIONS(NUM_REGIONS)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .base_we  (base_acc),
      .base_idx (base_tgt),
      .base_in  (wdata[DATA_W-1:BASE_LSB]),
      .attr_we  (attr_acc),
      .attr_idx (sel_q),
      .size_in  (wdata[15:0]),
      .acc_in   (wdata[31:16]),
      .rd_idx   (sel_q),
      .rd_base  (rd_base),
      .rd_size  (rd_size),
      .rd_acc   (rd_acc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         sel_q     <= '0;
         changed_q <= 1'b0;
         bad_q     <= 1'b0;
      end else begin
         if (wr_ctrl)
            ctrl_q <= wdata[2:0];
         if (wr_sel && sel_val_ok)
            sel_q <= wdata[IDX_W-1:0];
         else if (base_acc && wdata[4])
            sel_q <= wdata[IDX_W-1:0];
         changed_q <= wr_ctrl || base_acc || attr_acc;
         bad_q     <= wr_ctrl && wdata[1:0] == 2'b10;
      end
   end

   always_comb begin
      rdata = '0;
      unique case (kind)
         RK_INFO: rdata = {16'h0, 8'(NUM_REGIONS), 8'h0};
         RK_CTRL: rdata = {29'h0, ctrl_q};
         RK_SEL:  rdata = {28'h0, sel_q};
         RK_BASE: if (sel_ok) rdata = {rd_base, 1'b0, sel_q};
         RK_ATTR: if (sel_ok) rdata = {rd_acc, rd_size};
         default: rdata = '0;
      endcase
   end

   assign prot_changed = changed_q;
   assign ctrl_bad     = bad_q;
endmodule

// File: rtl/mpu_regfile_chk.sv
module mpu_regfile_chk
   import mpu_regfile_pkg::*;
#(
   parameter int NUM_REGIONS = 8
) (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [11:0] addr,
   input logic [31:0] wdata,
   input logic [31:0] rdata,
   input logic        prot_changed,
   input logic        ctrl_bad,
   input logic [2:0]  ctrl_q,
   input logic [3:0]  sel_q
);
   logic wr_ctrl, wr_sel;
   assign wr_ctrl = wr_en && addr == OFF_CTRL;
   assign wr_sel  = wr_en && addr == OFF_SEL;

   p_info_ro_r1: assert property (@(posedge clk) disable iff (!rst_n)
      addr == OFF_INFO |-> rdata == {16'h0, 8'(NUM_REGIONS), 8'h0});

   p_ctrl_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> ctrl_q == $past(wdata[2:0]));

   p_bad_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl && wdata[1:0] == 2'b10 |=> ctrl_bad);

   p_bad_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_bad |-> $past(wr_ctrl));

   p_sel_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel && wdata >= 32'(NUM_REGIONS) |=> $stable(sel_q));

   p_chg_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      prot_changed |-> $past(wr_en));

   p_ctrl_chg_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> prot_changed);

   p_sel_nochg_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel |=> !prot_changed);

   generate
      if (NUM_REGIONS > 0) begin : g_range
         p_sel_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
            {1'b0, sel_q} < 5'(NUM_REGIONS));
      end
   endgenerate
endmodule

bind mpu_regfile mpu_regfile_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .addr         (addr),
   .wdata        (wdata),
   .rdata        (rdata),
   .prot_changed (prot_changed),
   .ctrl_bad     (ctrl_bad),
   .ctrl_q       (ctrl_q),
   .sel_q        (sel_q)
);

// File: tb/mpu_regfile_test.sv
module mpu_regfile_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        prot_changed, ctrl_bad;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   mpu_regfile #(.NUM_REGIONS(8)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .prot_changed(prot_changed), .ctrl_bad(ctrl_bad)
   );

   typedef struct {
      bit          chk_rd;
      logic [31:0] exp;
      bit          exp_chg;
      bit          exp_bad;
      string       tag;
   } item_t;

   item_t q[$];
   bit pend_chg = 1'b0;
   bit pend_bad = 1'b0;

   // Driver: one access per cycle, driven 2 ns after the rising edge.
   task automatic access(input bit wr, input logic [11:0] a, input logic [31:0] d,
                         input bit chk, input logic [31:0] exp,
                         input bit acc, input bit bad, input string tag);
      item_t it;
      @(posedge clk);
      #2;
      wr_en = wr;
      addr  = a;
      wdata = d;
      it.chk_rd  = chk;
      it.exp     = exp;
      it.exp_chg = pend_chg;
      it.exp_bad = pend_bad;
      it.tag     = tag;
      q.push_back(it);
      pend_chg = wr && acc;
      pend_bad = wr && bad;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      access(1'b0, a, '0, 1'b1, exp, 1'b0, 1'b0, tag);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d,
                     input bit acc, input bit bad, input string tag);
      access(1'b1, a, d, 1'b0, '0, acc, bad, tag);
   endtask

   // Monitor: sample at the falling edge, compare against the queue.
   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         if (it.chk_rd) begin
            checks++;
            if (rdata !== it.exp) begin
               errors++;
               $display("FAIL %s: rdata actual %h expected %h", it.tag, rdata, it.exp);
            end
         end
         checks++;
         if (prot_changed !== it.exp_chg) begin
            errors++;
            $display("FAIL %s (R10): prot_changed actual %b expected %b",
                     it.tag, prot_changed, it.exp_chg);
         end
         checks++;
         if (ctrl_bad !== it.exp_bad) begin
            errors++;
            $display("FAIL %s (R3): ctrl_bad actual %b expected %b",
                     it.tag, ctrl_bad, it.exp_bad);
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R11 reset state
      rd(12'hD90, 32'h0000_0800, "R11 R1 info after reset");
      rd(12'hD94, 32'h0, "R11 ctrl after reset");
      rd(12'hD98, 32'h0, "R11 selector after reset");
      rd(12'hD9C, 32'h0, "R11 base after reset");
      rd(12'hDA0, 32'h0, "R11 attr after reset");
      // R1 read-only
      wr(12'hD90, 32'hFFFF_FFFF, 1'b0, 1'b0, "R1 info write");
      rd(12'hD90, 32'h0000_0800, "R1 info unchanged");
      // R2 / R3 control
      wr(12'hD94, 32'hFFFF_FFFD, 1'b1, 1'b0, "R2 ctrl wide write");
      rd(12'hD94, 32'h5, "R2 ctrl masked");
      wr(12'hD94, 32'h2, 1'b1, 1'b1, "R3 undefined ctrl");
      rd(12'hD94, 32'h2, "R3 ctrl stored");
      wr(12'hD94, 32'h3, 1'b1, 1'b0, "R3 legal ctrl");
      rd(12'hD94, 32'h3, "R2 ctrl readback");
      // R4 selector
      wr(12'hD98, 32'h3, 1'b0, 1'b0, "R4 select 3");
      rd(12'hD98, 32'h3, "R4 selector 3");
      wr(12'hD98, 32'h8, 1'b0, 1'b0, "R4 select 8");
      rd(12'hD98, 32'h3, "R4 select 8 ignored");
      wr(12'hD98, 32'h13, 1'b0, 1'b0, "R4 select 0x13");
      rd(12'hD98, 32'h3, "R4 select 0x13 ignored");
      // R5 out-of-range own region drops all
      wr(12'hD9C, 32'h2000_00FF, 1'b0, 1'b0, "R5 base to region 15");
      rd(12'hD98, 32'h3, "R5 selector kept");
      rd(12'hD9C, 32'h0000_0003, "R5 base region 3 untouched");
      // R6 base via selector
      wr(12'hD9C, 32'h1234_56E7, 1'b1, 1'b0, "R6 base via selector");
      rd(12'hD9C, 32'h1234_56E3, "R6 base readback");
      // R5 base with own region
      wr(12'hD9C, 32'hABCD_0015, 1'b1, 1'b0, "R5 base own region 5");
      rd(12'hD98, 32'h5, "R5 selector moved");
      rd(12'hD9C, 32'hABCD_0005, "R5 base region 5");
      // R7 attribute masks
      wr(12'hDA0, 32'hFFFF_FFFF, 1'b1, 1'b0, "R7 attr all ones");
      rd(12'hDA0, 32'h173F_FF3F, "R7 attr masked");
      // R8 aliases
      rd(12'hDA4, 32'hABCD_0005, "R8 alias1 base");
      rd(12'hDA8, 32'h173F_FF3F, "R8 alias1 attr");
      wr(12'hDAC, 32'h0000_0013, 1'b1, 1'b0, "R8 alias2 base own region 3");
      rd(12'hDB4, 32'h0000_0003, "R8 alias3 base region 3");
      rd(12'hDB0, 32'h0, "R8 alias2 attr region 3");
      wr(12'hDB8, 32'h1234_5678, 1'b1, 1'b0, "R8 alias3 attr write");
      rd(12'hDA0, 32'h1234_5638, "R8 R7 attr via primary");
      // R9 unknown offsets
      wr(12'hDBC, 32'hFFFF_FFFF, 1'b0, 1'b0, "R9 unknown write");
      rd(12'hDBC, 32'h0, "R9 unknown read");
      rd(12'hD8C, 32'h0, "R9 unknown read below");
      rd(12'hD94, 32'h3, "R9 ctrl untouched");
      rd(12'hDA0, 32'h1234_5638, "R9 attr untouched");
      // region 5 kept its data
      wr(12'hD98, 32'h5, 1'b0, 1'b0, "R4 select 5");
      rd(12'hDA0, 32'h173F_FF3F, "R8 region 5 attr kept");
      // highest region
      wr(12'hDB4, 32'h8000_0017, 1'b1, 1'b0, "R5 base own region 7");
      rd(12'hD98, 32'h7, "R5 selector 7");
      rd(12'hD9C, 32'h8000_0007, "R6 base region 7");
      rd(12'hD90, 32'h0000_0800, "R1 info final");
      @(posedge clk);
      #2 wr_en = 1'b0;
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule